// File: doc/BRIEF.md
# Four-Bit Sector ECC Correction Sequencer

This block drives the correction of one 512-byte sector that is protected by a code of eight 10-bit symbols, which can repair up to four bad bytes. A pulse on `start` comes with the ten stored code bytes. The block first looks at those bytes. If they show an erased page, it stops at once. Otherwise it unpacks the bytes into eight symbols and streams them into an external syndrome and locator engine.

The block then reads the engine's syndrome. If the syndrome is non-zero, it starts the locator calculation. It waits on the engine's status in two phases, which protects it from a false "complete" code that can appear just after the start. Last, it walks the reported error slots. Each slot inside the sector becomes a read-modify-write of one byte in a byte-addressed sector buffer.

The syndrome arithmetic and the locator arithmetic stay in the engine. This block only orders the steps, decodes the results and carries out the fixes. At the end it pulses `done`, together with the number of bytes written back or a failure flag.

Top module: `ecc4_fix_seq`

## Requirements
- R1: When all ten code bytes equal 0xFF at `start`, the block pulses `done` in the next cycle, with `fix_count` = 0 and `fail` = 0. It loads nothing into the engine and never starts it.
- R2: Code byte k sits on `code_in[8k+7:8k]`. Symbol j is taken from bits `[10j+9:10j]` of that little-endian bit string.
- R3: A non-erased `start` is followed by exactly eight `eng_load_vld` cycles. They carry symbol 7 first and symbol 0 last.
- R4: If `eng_synd` is zero after the loads, the block finishes with `fix_count` = 0 and `fail` = 0, and it never pulses `eng_calc_start`.
- R5: A non-zero syndrome causes exactly one single-cycle `eng_calc_start`. After it, any `eng_state` below 4 is ignored until the state has read 4 or more, or until WAIT_CYC cycles have passed, whichever comes first.
- R6: Once the wait of R5 is over, `eng_state` is decoded as follows. A value of 0 finishes with no corrections and no failure. A value of 1 finishes with `fail` = 1 and no buffer access. A value of 2 or 3 starts the corrections. A value of 4 or more keeps the block waiting.
- R7: The number of errors is `eng_nerr` + 1. Errors 0 and 1 use `eng_addr_a` and `eng_val_a`, and errors 2 and 3 use `eng_addr_b` and `eng_val_b`. An even-numbered error takes bits [9:0] of its register and an odd-numbered error takes bits [25:16]. The fix applies bits [7:0] of the value field.
- R8: An error address A is mapped to byte offset 519 − A. The byte is touched only when 8 ≤ A ≤ 519. Any other address is skipped with no buffer access.
- R9: Each fix pulses `buf_rd` with the offset. In the next cycle it pulses `buf_wr` to the same offset, with `buf_wdata` = `buf_rdata` ^ value. Errors are handled in index order, so a repeated offset sees the earlier write.
- R10: `done` is a one-cycle pulse. `fix_count` equals the number of buffer writes made in the run and holds until the next `start`. `fail` is high only while `done` is high.
- R11: If `eng_state` stays at 4 or more for BUSY_CYC cycles after the initial wait, the block finishes with `fail` = 1 and makes no buffer access. If a decodable state arrives in the same cycle that this limit runs out, the decodable state wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one sector run (pulse) |
| code_in | input | 80 | Ten stored code bytes, byte k at [8k+7:8k] |
| done | output | 1 | Run finished (pulse) |
| fail | output | 1 | Uncorrectable or timed out, valid with done |
| fix_count | output | 3 | Bytes written back in the last run |
| eng_load_vld | output | 1 | Symbol load strobe to the engine |
| eng_load_val | output | 10 | Symbol value being loaded |
| eng_synd | input | 80 | Syndrome from the engine, zero means clean |
| eng_calc_start | output | 1 | Start the locator calculation (pulse) |
| eng_state | input | 4 | Engine status code |
| eng_nerr | input | 2 | Error count minus one |
| eng_addr_a | input | 32 | Error addresses 0 (low) and 1 (high) |
| eng_addr_b | input | 32 | Error addresses 2 (low) and 3 (high) |
| eng_val_a | input | 32 | Error values 0 (low) and 1 (high) |
| eng_val_b | input | 32 | Error values 2 (low) and 3 (high) |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd | output | 1 | Buffer read strobe, data in the next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |

## Verification
Two events can fall in the same cycle.

The first pair is the false "complete" code and the first cycle of the initial wait. The engine model holds state 3 from the very cycle after the start pulse. In some runs it then reports "uncorrectable", with valid in-range addresses sitting in the registers. An early acceptance would therefore show up as buffer writes where a failure is expected.

The second pair is the expiry of the initial-wait limit and the acceptance of a done code. One directed run holds state 3 past WAIT_CYC. That run must still complete its corrections through the timeout path.

// File: rtl/ecc4_pkg.sv
package ecc4_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SYND,
    ST_KICK,
    ST_PRE,
    ST_BUSY,
    ST_FRD,
    ST_FWR,
    ST_DONE
  } seq_st_e;

  localparam logic [3:0] ENG_CLEAN = 4'd0;
  localparam logic [3:0] ENG_FATAL = 4'd1;
  localparam logic [3:0] ENG_WORK  = 4'd4;
  localparam int HALF_SHIFT = 16;
endpackage

// File: rtl/ecc4_unpack.sv
module ecc4_unpack #(
  parameter int NBYTE = 10,
  parameter int SYM_W = 10,
  parameter int NSYM  = 8
) (
  input  logic [NBYTE*8-1:0]    code,
  output logic [NSYM*SYM_W-1:0] syms,
  output logic                  blank
);
  // Stored bytes form one little-endian bit string; symbols are consecutive slices.
  for (genvar j = 0; j < NSYM; j++) begin : g_sym
    assign syms[j*SYM_W +: SYM_W] = code[j*SYM_W +: SYM_W];
  end
  assign blank = &code;
endmodule

// File: rtl/ecc4_err_pick.sv
module ecc4_err_pick #(
  parameter int SYM_W  = 10,
  parameter int SECT   = 512,
  localparam int AW    = $clog2(SECT),
  localparam int BIAS  = SECT + 7
) (
  input  logic [1:0]    idx,
  input  logic [31:0]   addr_a,
  input  logic [31:0]   addr_b,
  input  logic [31:0]   val_a,
  input  logic [31:0]   val_b,
  output logic [AW-1:0] offset,
  output logic [7:0]    value,
  output logic          in_range
);
  import ecc4_pkg::*;
  logic [31:0]      aw, vw;
  logic [SYM_W-1:0] ah, vh;
  logic [SYM_W:0]   diff;
  logic             unused_bits;

  always_comb begin
    aw = idx[1] ? addr_b : addr_a;
    vw = idx[1] ? val_b  : val_a;
    ah = idx[0] ? aw[HALF_SHIFT +: SYM_W] : aw[SYM_W-1:0];
    vh = idx[0] ? vw[HALF_SHIFT +: SYM_W] : vw[SYM_W-1:0];
    diff     = (SYM_W+1)'(BIAS) - {1'b0, ah};
    in_range = ({1'b0, ah} >= (SYM_W+1)'(BIAS - SECT + 1)) && ({1'b0, ah} <= (SYM_W+1)'(BIAS));
    offset   = diff[AW-1:0];
    value    = vh[7:0];
  end
  assign unused_bits = ^{aw[31:26], aw[15:10], vh[SYM_W-1:8], vw[31:26], vw[15:10]};
endmodule

// File: rtl/ecc4_wait_cnt.sv
module ecc4_wait_cnt #(
  parameter int LIMIT = 100,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = run ? cnt + CW'(1) : '0;
    hit   = run && (cnt == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0) || !run);
endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq #(
  parameter int NBYTE    = 10,
  parameter int SYM_W    = 10,
  parameter int NSYM     = 8,
  parameter int SECT     = 512,
  parameter int WAIT_CYC = 5000,
  parameter int BUSY_CYC = 20000,
  localparam int AW      = $clog2(SECT),
  localparam int LW      = $clog2(NSYM)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NBYTE*8-1:0]    code_in,
  output logic                  done,
  output logic                  fail,
  output logic [2:0]            fix_count,
  output logic                  eng_load_vld,
  output logic [SYM_W-1:0]      eng_load_val,
  input  logic [NSYM*SYM_W-1:0] eng_synd,
  output logic                  eng_calc_start,
  input  logic [3:0]            eng_state,
  input  logic [1:0]            eng_nerr,
  input  logic [31:0]           eng_addr_a,
  input  logic [31:0]           eng_addr_b,
  input  logic [31:0]           eng_val_a,
  input  logic [31:0]           eng_val_b,
  output logic [AW-1:0]         buf_addr,
  output logic                  buf_rd,
  input  logic [7:0]            buf_rdata,
  output logic                  buf_wr,
  output logic [7:0]            buf_wdata
);
  import ecc4_pkg::*;

  seq_st_e               st, st_n;
  logic [LW-1:0]         li, li_n;
  logic [1:0]            eidx, eidx_n;
  logic [2:0]            nerr_q, nerr_n, fix_q, fix_n;
  logic                  fail_q, fail_n, syms_en;
  logic [NSYM*SYM_W-1:0] syms_w, syms_q;
  logic                  blank, pre_hit, busy_hit, in_range, last_err;
  logic [AW-1:0]         eoff;
  logic [7:0]            eval;

  ecc4_unpack #(.NBYTE(NBYTE), .SYM_W(SYM_W), .NSYM(NSYM)) u_unpack (
    .code(code_in), .syms(syms_w), .blank(blank));

  ecc4_err_pick #(.SYM_W(SYM_W), .SECT(SECT)) u_pick (
    .idx(eidx), .addr_a(eng_addr_a), .addr_b(eng_addr_b),
    .val_a(eng_val_a), .val_b(eng_val_b),
    .offset(eoff), .value(eval), .in_range(in_range));

  ecc4_wait_cnt #(.LIMIT(WAIT_CYC)) u_pre_wait (
    .clk(clk), .rst_n(rst_n), .run(st == ST_PRE), .hit(pre_hit));

  ecc4_wait_cnt #(.LIMIT(BUSY_CYC)) u_busy_wd (
    .clk(clk), .rst_n(rst_n), .run(st == ST_BUSY), .hit(busy_hit));

  assign last_err = ({1'b0, eidx} == nerr_q - 3'd1);

  // Next-state and output decode
  always_comb begin
    st_n = st; li_n = li; eidx_n = eidx; nerr_n = nerr_q;
    fix_n = fix_q; fail_n = fail_q; syms_en = 1'b0;
    eng_load_vld = 1'b0; eng_load_val = '0; eng_calc_start = 1'b0;
    buf_addr = '0; buf_rd = 1'b0; buf_wr = 1'b0; buf_wdata = '0;
    done = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        fix_n = '0; fail_n = 1'b0; syms_en = 1'b1; li_n = LW'(NSYM - 1);
        st_n = blank ? ST_DONE : ST_LOAD;
      end
      ST_LOAD: begin
        eng_load_vld = 1'b1;
        eng_load_val = syms_q[li*SYM_W +: SYM_W];
        if (li == '0) st_n = ST_SYND;
        else          li_n = li - LW'(1);
      end
      ST_SYND: st_n = (eng_synd == '0) ? ST_DONE : ST_KICK;
      ST_KICK: begin
        eng_calc_start = 1'b1;
        st_n = ST_PRE;
      end
      // A low status right after the kick is not trusted until work is seen.
      ST_PRE: if (eng_state >= ENG_WORK || pre_hit) st_n = ST_BUSY;
      ST_BUSY: begin
        if (eng_state == ENG_CLEAN) st_n = ST_DONE;
        else if (eng_state == ENG_FATAL) begin
          fail_n = 1'b1; st_n = ST_DONE;
        end else if (eng_state < ENG_WORK) begin
          nerr_n = {1'b0, eng_nerr} + 3'd1; eidx_n = '0; st_n = ST_FRD;
        end else if (busy_hit) begin
          fail_n = 1'b1; st_n = ST_DONE;
        end
      end
      ST_FRD: begin
        if (in_range) begin
          buf_rd = 1'b1; buf_addr = eoff; st_n = ST_FWR;
        end else if (last_err) st_n = ST_DONE;
        else eidx_n = eidx + 2'd1;
      end
      ST_FWR: begin
        buf_wr = 1'b1; buf_addr = eoff; buf_wdata = buf_rdata ^ eval;
        fix_n = fix_q + 3'd1;
        if (last_err) st_n = ST_DONE;
        else begin
          eidx_n = eidx + 2'd1; st_n = ST_FRD;
        end
      end
      ST_DONE: begin
        done = 1'b1; st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; li <= '0; eidx <= '0; nerr_q <= '0;
      fix_q <= '0; fail_q <= 1'b0;
    end else begin
      st <= st_n; li <= li_n; eidx <= eidx_n; nerr_q <= nerr_n;
      fix_q <= fix_n; fail_q <= fail_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       syms_q <= '0;
    else if (syms_en) syms_q <= syms_w;
  end

  assign fail      = fail_q && done;
  assign fix_count = fix_q;

  a_r1_blank_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (start && blank && st == ST_IDLE) |=> !eng_load_vld && done);
  a_r5_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_calc_start |=> !eng_calc_start);
  a_r9_rmw_pair: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $past(buf_rd) && ($past(buf_addr) == buf_addr));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> fix_count <= 3'd4);
endmodule

// File: tb/sim_ecc4_fix_seq.sv
module sim_ecc4_fix_seq;
  localparam int CLK_NS = 10;
  localparam int WAITC  = 20;
  localparam int BUSYC  = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [79:0] code_in = '0, eng_synd = '0;
  logic done, fail, eng_load_vld, eng_calc_start, buf_rd, buf_wr;
  logic [2:0] fix_count;
  logic [9:0] eng_load_val;
  logic [3:0] eng_state;
  logic [1:0] eng_nerr = '0;
  logic [31:0] eng_addr_a = '0, eng_addr_b = '0, eng_val_a = '0, eng_val_b = '0;
  logic [8:0] buf_addr;
  logic [7:0] buf_rdata, buf_wdata;

  ecc4_fix_seq #(.WAIT_CYC(WAITC), .BUSY_CYC(BUSYC)) u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  // Engine model: false "complete" for m_spur cycles, busy for m_work, then m_fin.
  int m_spur = 0, m_work = 0, tk = 0;
  logic [3:0] m_fin = '0;
  logic running = 1'b0;
  always @(posedge clk) begin
    if (start) running <= 1'b0;
    else if (eng_calc_start) begin running <= 1'b1; tk <= 0; end
    else if (running) tk <= tk + 1;
  end
  assign eng_state = !running ? 4'd0 : (tk < m_spur) ? 4'd3 :
                     (tk < m_spur + m_work) ? 4'd8 : m_fin;

  // Capture of loads, kicks and buffer writes; sector buffer model.
  logic [9:0] ld [8];
  int nld = 0, nkick = 0, nwr = 0, seedb = 0;
  logic fill_req = 1'b0;
  logic [7:0] mem [512];
  logic [7:0] gold [512];

  function automatic logic [7:0] pat(int i, int s);
    return 8'(i * 37 + s * 11 + 5);
  endfunction

  always @(posedge clk) begin
    if (start) begin nld <= 0; nkick <= 0; nwr <= 0; end
    if (eng_load_vld) begin
      if (nld < 8) ld[nld] <= eng_load_val;
      nld <= nld + 1;
    end
    if (eng_calc_start) nkick <= nkick + 1;
    if (fill_req) for (int i = 0; i < 512; i++) mem[i] <= pat(i, seedb);
    if (buf_rd) buf_rdata <= mem[buf_addr];
    if (buf_wr) begin mem[buf_addr] <= buf_wdata; nwr <= nwr + 1; end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] sym_of(logic [79:0] c, int j);
    logic [9:0] s;
    for (int b = 0; b < 10; b++) s[b] = c[(10 * j + b) / 8 * 8 + (10 * j + b) % 8];
    return s;
  endfunction

  task automatic run_case(input logic [79:0] c, input logic [79:0] sy, input logic [1:0] ne,
                          input logic [31:0] a0, input logic [31:0] a1,
                          input logic [31:0] v0, input logic [31:0] v1,
                          input int sp, input int wk, input logic [3:0] fin);
    int cyc, efix, eld, ekick, mism;
    bit efail, blank, ldok;
    @(negedge clk);
    code_in = c; eng_synd = sy; eng_nerr = ne; eng_addr_a = a0; eng_addr_b = a1;
    eng_val_a = v0; eng_val_b = v1; m_spur = sp; m_work = wk; m_fin = fin;
    seedb = $urandom % 256; fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R10", "done seen (watchdog)", int'(done), 1);
    for (int i = 0; i < 512; i++) gold[i] = pat(i, seedb);
    blank = (c == '1); efix = 0; efail = 1'b0; eld = 8; ekick = 1;
    if (blank) begin
      eld = 0; ekick = 0;
      chk(cyc == 1, "R1", "erased latency", cyc, 1);
    end else if (sy == '0) ekick = 0;
    else if (wk >= 100) efail = 1'b1;
    else if (fin == 4'd1) efail = 1'b1;
    else if (fin != 4'd0) begin
      for (int i = 0; i <= int'(ne); i++) begin
        logic [31:0] aw, vw; logic [9:0] ad, vd;
        aw = (i < 2) ? a0 : a1; vw = (i < 2) ? v0 : v1;
        ad = i[0] ? aw[25:16] : aw[9:0]; vd = i[0] ? vw[25:16] : vw[9:0];
        if (ad >= 10'd8 && ad <= 10'd519) begin
          gold[519 - int'(ad)] ^= vd[7:0]; efix++;
        end
      end
    end
    chk(fail === efail, "R6", "fail flag", int'(fail), int'(efail));
    chk(fix_count == 3'(efix), "R10", "fix_count", int'(fix_count), efix);
    chk(nld == eld, "R3", "load count", nld, eld);
    ldok = 1'b1;
    if (eld == 8) for (int k = 0; k < 8; k++) if (ld[k] !== sym_of(c, 7 - k)) ldok = 1'b0;
    chk(ldok, "R2", "load order/values", int'(ldok), 1);
    chk(nkick == ekick, "R4", "calc start count", nkick, ekick);
    chk(nwr == efix, "R9", "buffer writes", nwr, efix);
    mism = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== gold[i]) mism++;
    chk(mism == 0, "R8", "sector bytes mismatching", mism, 0);
    @(negedge clk);
    chk(done === 1'b0 && fail === 1'b0, "R10", "done single pulse", int'(done), 0);
  endtask

  function automatic logic [31:0] pair(logic [9:0] hi, logic [9:0] lo);
    return {6'h2A, hi, 6'h15, lo};
  endfunction

  initial begin
    logic [79:0] c, sy;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && eng_load_vld === 1'b0 && buf_wr === 1'b0 && buf_rd === 1'b0,
        "R10", "reset outputs idle", int'(done), 0);
    chk(fix_count == 3'd0, "R10", "reset fix_count", int'(fix_count), 0);
    rst_n = 1'b1;
    c = {$urandom, $urandom, $urandom};
    // R1 erased page
    run_case('1, 80'h1, 2'd3, pair(10'd20, 10'd30), pair(10'd40, 10'd50), '1, '1, 0, 2, 4'd2);
    // R4 clean syndrome
    run_case(c, '0, 2'd1, pair(10'd20, 10'd30), '0, '1, '1, 0, 2, 4'd2);
    // R5 false complete then uncorrectable: no writes allowed
    run_case(c, 80'h5, 2'd3, pair(10'd100, 10'd200), pair(10'd300, 10'd400), '1, '1, 3, 5, 4'd1);
    // R7/R8 four slots, two out of range at both edges
    run_case(c, 80'h9, 2'd3, pair(10'd7, 10'd8), pair(10'd520, 10'd519),
             pair(10'h3C3, 10'h2A5), pair(10'h15A, 10'h1FF), 1, 3, 4'd3);
    // R9 repeated offset
    run_case(c, 80'h9, 2'd1, pair(10'd100, 10'd100), '0, pair(10'h0F, 10'hF0), '0, 0, 4, 4'd2);
    // R5 initial wait expires while status still reads 3
    run_case(c, 80'h3, 2'd0, pair(10'd0, 10'd300), '0, pair(10'd0, 10'h81), '0, 25, 0, 4'd2);
    // R11 engine never finishes
    run_case(c, 80'h3, 2'd2, pair(10'd60, 10'd70), pair(10'd0, 10'd90), '1, '1, 0, 200, 4'd2);
    // R6 status 0 after work
    run_case(c, 80'h3, 2'd2, pair(10'd60, 10'd70), pair(10'd0, 10'd90), '1, '1, 2, 3, 4'd0);
    for (int n = 0; n < 40; n++) begin
      logic [9:0] ad [4];
      logic [3:0] f;
      c = {$urandom, $urandom, $urandom};
      sy = ($urandom % 8 == 0) ? '0 : {$urandom, $urandom, $urandom};
      for (int k = 0; k < 4; k++) ad[k] = ($urandom % 2) ? 10'(8 + $urandom % 512) : 10'($urandom);
      f = ($urandom % 6 == 0) ? 4'(($urandom % 2)) : 4'(2 + $urandom % 2);
      run_case(c, sy, 2'($urandom), pair(ad[1], ad[0]), pair(ad[3], ad[2]),
               $urandom, $urandom, $urandom % 4, $urandom % 12, f);
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule